// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a system against a stalled processor. Software programs it by writing one 32-bit control word. The word carries a 7-bit key, a start/stop command and a reload count. Once the watchdog is running, a write is honoured only if its key is the bitwise inverse of the key taken from the last honoured write. Each honoured write therefore needs a fresh key. A stray or runaway store that repeats an old value cannot keep the watchdog alive.

The countdown moves only on cycles where a slow tick enable is high. When the count runs out for the first time, the block raises a non-maskable interrupt and starts a short grace countdown. An honoured write during the grace countdown clears the interrupt and restarts or stops the watchdog. If the grace countdown also runs out, the block emits a one-cycle reset request. It then stays tripped until the next reset. Generating the system reset itself is left to the surrounding logic.

The controller is a four-state machine:
- `ST_IDLE`: stopped.
- `ST_COUNT`: the main countdown is running.
- `ST_GRACE`: the interrupt is raised and the grace countdown is running.
- `ST_TRIPPED`: terminal until reset.

The transitions are:
- *arm*: any non-tripped state goes to `ST_COUNT` on an honoured write with the command bit set.
- *disarm*: any non-tripped state goes to `ST_IDLE` on an honoured write with the command bit clear.
- *expire*: `ST_COUNT` goes to `ST_GRACE` on a tick while the count is 1.
- *escalate*: `ST_GRACE` goes to `ST_TRIPPED` on a tick while the grace count is 1.
- *reset*: any state goes to `ST_IDLE`.

Top module: `keyed_watchdog`

## Requirements
- R1: The control word fields are: key in wr_data[15:9], command in wr_data[8], reload count in wr_data[CNT_W-1:0]. All other bits have no effect on behaviour.
- R2: After reset, nmi_o and rst_req_o are low. The watchdog is stopped, so any number of ticks gives no expiry.
- R3: While armed (the last honoured write had command 1), a write whose key is not the bitwise inverse of the stored key is ignored. The outputs and the countdown continue unchanged.
- R4: While not armed, every write is honoured whatever its key.
- R5: An honoured write with command 1 loads the count N and starts the countdown. nmi_o rises in the cycle after the N-th following tick. A count field of 0 means N = 2^CNT_W.
- R6: An honoured write with command 0 loads the count and stops the countdown. No further expiry occurs, and nmi_o is low from the next cycle.
- R7: Cycles with tick_en low never advance the countdown.
- R8: nmi_o rises only on first expiry and stays high throughout the grace stage.
- R9: An honoured write during the grace stage lowers nmi_o in the next cycle and applies its command. No reset request follows.
- R10: After GRACE_TICKS ticks in the grace stage, rst_req_o is high for exactly one cycle, in the cycle after the last grace tick.
- R11: Once the reset request has been issued, writes are ignored, nmi_o stays high and no further request occurs until reset.
- R12: An honoured write in the same cycle as a tick takes priority: the count is reloaded and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow tick; one countdown step per high cycle |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word: key, command, reload count |
| nmi_o | output | 1 | Non-maskable interrupt, first expiry stage |
| rst_req_o | output | 1 | One-cycle reset request, second expiry stage |

## Verification
The bench builds the block with CNT_W = 4 and GRACE_TICKS = 3. This brings the zero-means-full-range reload (16 ticks) and a full escalation to the tripped state within a few dozen cycles. Random writes with right and wrong keys then reach the expire and escalate transitions many times. That mix also covers writes that collide with ticks, and writes that land in every state, including the grace and tripped stages.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_GRACE   = 2'd2,
        ST_TRIPPED = 2'd3
    } kwd_state_e;

    // Control word field positions
    localparam int KEY_W   = 7;
    localparam int KEY_LSB = 9;
    localparam int CMD_BIT = 8;

endpackage

// File: rtl/kwd_keygate.sv
// Holds the key from the last honoured write and the armed flag, and
// judges whether a new key may pass.
module kwd_keygate #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_cmd,
    input  logic             commit,
    output logic             key_ok,
    output logic             armed
);

    logic [KEY_W-1:0] key_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q   <= '0;
            armed_q <= 1'b0;
        end else if (commit) begin
            key_q   <= wr_key;
            armed_q <= wr_cmd;
        end
    end

    // Unarmed: anything passes. Armed: the key must be the inverse.
    assign key_ok = !armed_q || (wr_key == ~key_q);
    assign armed  = armed_q;

endmodule

// File: rtl/kwd_counter.sv
// Down-counter shared by the main and grace stages.
module kwd_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          at_one
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_one = (cnt_q == CW'(1));

endmodule

// File: rtl/kwd_fsm.sv
// Stage controller: decides write acceptance, counter loads and outputs.
module kwd_fsm
    import kwd_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int GRACE_TICKS = 10,
    localparam int CW         = CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic          wr_cmd,
    input  logic          key_ok,
    input  logic [CW-1:0] reload_val,
    input  logic          at_one,
    output logic          commit,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_load_val,
    output logic          cnt_dec,
    output logic          nmi_o,
    output logic          rst_req_o
);

    localparam logic [CW-1:0] GRACE_V = CW'(GRACE_TICKS);

    kwd_state_e state_q, state_d;
    logic       nmi_q, req_q;
    logic       accept;

    // A tripped watchdog accepts nothing until reset
    assign accept = wr_en && key_ok && (state_q != ST_TRIPPED);

    always_comb begin
        state_d      = state_q;
        commit       = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = reload_val;
        cnt_dec      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    commit   = 1'b1;
                    cnt_load = 1'b1;
                    state_d  = wr_cmd ? ST_COUNT : ST_IDLE;
                end
            end
            ST_COUNT: begin
                if (accept) begin
                    commit   = 1'b1;
                    cnt_load = 1'b1;
                    state_d  = wr_cmd ? ST_COUNT : ST_IDLE;
                end else if (tick_en) begin
                    if (at_one) begin
                        cnt_load     = 1'b1;
                        cnt_load_val = GRACE_V;
                        state_d      = ST_GRACE;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_GRACE: begin
                if (accept) begin
                    commit   = 1'b1;
                    cnt_load = 1'b1;
                    state_d  = wr_cmd ? ST_COUNT : ST_IDLE;
                end else if (tick_en) begin
                    if (at_one) begin
                        state_d = ST_TRIPPED;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            nmi_q <= (state_d == ST_GRACE) || (state_d == ST_TRIPPED);
            req_q <= (state_q == ST_GRACE) && (state_d == ST_TRIPPED);
        end
    end

    assign nmi_o     = nmi_q;
    assign rst_req_o = req_q;

endmodule

// File: rtl/keyed_watchdog.sv
// Keyed watchdog with interrupt-then-reset escalation.
// CNT_W must be 1..8 (count field sits below the command bit);
// GRACE_TICKS must be 1..2**CNT_W.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int GRACE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              nmi_o,
    output logic              rst_req_o
);

    localparam int CW = CNT_W + 1;

    logic [KEY_W-1:0] wr_key;
    logic             wr_cmd;
    logic [CNT_W-1:0] wr_cnt;
    logic [CW-1:0]    reload_val;
    logic             key_ok, armed, commit;
    logic             cnt_load, cnt_dec, at_one;
    logic [CW-1:0]    cnt_load_val;
    logic             ctl_unused;

    assign wr_key = wr_data[KEY_LSB +: KEY_W];
    assign wr_cmd = wr_data[CMD_BIT];
    assign wr_cnt = wr_data[CNT_W-1:0];
    assign ctl_unused = ^{wr_data[DATA_W-1:KEY_LSB+KEY_W], wr_data[CMD_BIT-1:0], armed};

    // A zero count field stands for the full range
    assign reload_val = (wr_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, wr_cnt};

    kwd_keygate #(.KEY_W(KEY_W)) u_keygate (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_key (wr_key),
        .wr_cmd (wr_cmd),
        .commit (commit),
        .key_ok (key_ok),
        .armed  (armed)
    );

    kwd_counter #(.CW(CW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .at_one   (at_one)
    );

    kwd_fsm #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .wr_en        (wr_en),
        .wr_cmd       (wr_cmd),
        .key_ok       (key_ok),
        .reload_val   (reload_val),
        .at_one       (at_one),
        .commit       (commit),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .cnt_dec      (cnt_dec),
        .nmi_o        (nmi_o),
        .rst_req_o    (rst_req_o)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic wr_en,
    input logic nmi_o,
    input logic rst_req_o
);

    logic tripped_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)         tripped_seen <= 1'b0;
        else if (rst_req_o) tripped_seen <= 1'b1;
    end

    // R8: the interrupt only rises in response to a tick
    a_r8_nmi_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(tick_en));

    // R9: the interrupt only falls in response to a write
    a_r9_nmi_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_o) |-> $past(wr_en));

    // R10: the request lasts one cycle
    a_r10_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R10: the request only comes after a tick, with the interrupt up
    a_r10_req_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(tick_en) && nmi_o));

    // R11: after the request, no second request and the interrupt holds
    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        tripped_seen |-> (!rst_req_o && nmi_o));

endmodule

bind keyed_watchdog kwd_checker u_kwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

    localparam int CNT_W = 4;
    localparam int GRACE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        nmi_o, rst_req_o;

    int n_chk = 0;
    int n_fail = 0;

    // Bench reference state: 0 idle, 1 count, 2 grace, 3 tripped
    int         m_st;
    int         m_cnt;
    logic [6:0] m_key;
    logic       m_en, m_nmi, m_req;

    keyed_watchdog #(.DATA_W(32), .CNT_W(CNT_W), .GRACE_TICKS(GRACE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, act=timeout exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic [31:0] mkw(input logic [6:0] k, input logic c, input logic [3:0] n);
        return {16'h0000, k, c, 4'h0, n};
    endfunction

    function automatic int reload_of(input logic [31:0] d);
        return (d[CNT_W-1:0] == '0) ? (1 << CNT_W) : int'(d[CNT_W-1:0]);
    endfunction

    function automatic logic accepts(input logic [31:0] d);
        return (m_st != 3) && (!m_en || (d[15:9] == ~m_key));
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic t, input logic w, input logic [31:0] d);
        m_req = 1'b0;
        if (w && accepts(d)) begin
            m_key = d[15:9];
            m_en  = d[8];
            m_cnt = reload_of(d);
            m_st  = d[8] ? 1 : 0;
            m_nmi = 1'b0;
        end else if (t) begin
            if (m_st == 1) begin
                if (m_cnt == 1) begin m_st = 2; m_cnt = GRACE; m_nmi = 1'b1; end
                else m_cnt--;
            end else if (m_st == 2) begin
                if (m_cnt == 1) begin m_st = 3; m_req = 1'b1; end
                else m_cnt--;
            end
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [31:0] d);
        @(negedge clk);
        tick_en = t;
        wr_en   = w;
        wr_data = d;
        @(posedge clk);
        #2;
        model_step(t, w, d);
        chk("R8", nmi_o, m_nmi);
        chk("R10", rst_req_o, m_req);
        tick_en = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        m_st = 0; m_cnt = 0; m_key = '0; m_en = 1'b0; m_nmi = 1'b0; m_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        chk("R2", nmi_o, 1'b0);
        chk("R2", rst_req_o, 1'b0);
        repeat (40) cyc(1, 0, '0);
        chk("R2", nmi_o, 1'b0);

        // Unarmed write with any key, count 5, ticks spaced by idle cycles
        cyc(0, 1, mkw(7'h15, 1'b1, 4'd5));
        for (int i = 0; i < 4; i++) begin
            cyc(1, 0, '0);
            repeat (3) cyc(0, 0, '0);
        end
        chk("R7", nmi_o, 1'b0);
        cyc(1, 0, '0);
        chk("R5", nmi_o, 1'b1);

        // Grace stage: wrong key ignored, inverse key with stop clears
        cyc(0, 1, mkw(7'h15, 1'b1, 4'd4));
        chk("R3", nmi_o, 1'b1);
        cyc(0, 1, mkw(7'h6A, 1'b0, 4'd3));
        chk("R9", nmi_o, 1'b0);
        repeat (20) cyc(1, 0, '0);
        chk("R6", nmi_o, 1'b0);
        chk("R9", rst_req_o, 1'b0);

        // Zero count means full range, then full escalation
        cyc(0, 1, mkw(7'h01, 1'b1, 4'd0));
        chk("R4", nmi_o, 1'b0);
        repeat (15) cyc(1, 0, '0);
        chk("R5", nmi_o, 1'b0);
        cyc(1, 0, '0);
        chk("R5", nmi_o, 1'b1);
        repeat (2) cyc(1, 0, '0);
        chk("R10", rst_req_o, 1'b0);
        cyc(1, 0, '0);
        chk("R10", rst_req_o, 1'b1);
        cyc(0, 0, '0);
        chk("R10", rst_req_o, 1'b0);
        cyc(0, 1, mkw(7'h7E, 1'b0, 4'd2));
        chk("R11", nmi_o, 1'b1);
        repeat (20) cyc(1, 0, '0);
        chk("R11", rst_req_o, 1'b0);
        chk("R11", nmi_o, 1'b1);

        // Write colliding with tick, with junk in the ignored bits
        do_reset();
        chk("R2", nmi_o, 1'b0);
        cyc(0, 1, mkw(7'h0F, 1'b1, 4'd2));
        cyc(1, 0, '0);
        cyc(1, 1, mkw(7'h70, 1'b1, 4'd2) | 32'hABCD_00A0);
        chk("R12", nmi_o, 1'b0);
        cyc(1, 0, '0);
        chk("R1", nmi_o, 1'b0);
        cyc(1, 0, '0);
        chk("R12", nmi_o, 1'b1);

        // Random phase against the bench reference
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            logic       t, w, c;
            logic [6:0] k;
            logic [3:0] n;
            logic [31:0] d;
            if (($urandom % 700) == 0) do_reset();
            t = (($urandom % 3) == 0);
            w = (($urandom % 8) == 0);
            k = (($urandom % 3) != 0) ? ~m_key : 7'($urandom);
            c = (($urandom % 4) != 0);
            n = 4'($urandom);
            d = mkw(k, c, n) | ({$urandom} & 32'hFFFF_00F0);
            cyc(t, w, d);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule